// File: doc/BRIEF.md
# Two-Stage Delta-Sigma Bitstream Combiner

This block sits between a cascaded 2+2 delta-sigma modulator and a decimation filter. It divides the master clock by four to make the modulator clock. On each rising edge of that clock it captures one bit from each modulator stage. It then folds the two one-bit streams into a single signed sample. The fold is a fixed noise-cancelling sum: three delayed first-stage bits and a second difference of the second-stage bits. The sample is presented with a one-cycle valid strobe at the modulator rate.

A synchronization strobe restarts the divider at a known phase, so that several converters can be aligned to an external event. It also empties the bit history. A settled flag tells the downstream filter when enough fresh modulator samples have arrived since the last restart for the output to be free of cleared history.

Top module: `dsm_stream_merge`

## Requirements
- R1: `mod_clk` has a period of four `clk` cycles and is high for two of them.
- R2: When `sync_i` is high at a `clk` rising edge, `mod_clk` goes low after that edge and stays low. It rises again after the fifth following edge, then keeps the four-cycle period.
- R3: `rst_n` clears the block asynchronously and is released through two synchronizing flops. `mod_clk` first rises after the seventh `clk` edge that follows the release, and all outputs read zero while in reset.
- R4: `sample_vld` is a one-cycle pulse that is high exactly in the first `clk` cycle of each high phase of `mod_clk`.
- R5: The bits taken for a sample are the values of `m0_bit` and `m1_bit` at the `clk` edge where `mod_clk` rises.
- R6: Each bit maps 1 to +1 and 0 to -1. The sample is the sum 9·(M1[n] − 2·M1[n−1] + M1[n−2]) + 3·M0[n−2] − 6·M0[n−3] + 4·M0[n−4], with n the newest capture. It is written to `sample_o` as an `OUT_W`-bit two's complement value together with `sample_vld`, and held unchanged between pulses.
- R7: Reset and `sync_i` empty the history. A missing older bit contributes 0 to the sum until it has been captured afresh.
- R8: `settled` goes low after reset or a `sync_i` edge. It goes high together with the sixteenth `sample_vld` pulse after it, and stays high until the next reset or `sync_i`.
- R9: A `sync_i` at the edge where a capture would have occurred takes no sample, and `sample_vld` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Phase restart strobe, sampled on `clk` rising edge |
| m0_bit | input | 1 | First-stage modulator bit |
| m1_bit | input | 1 | Second-stage modulator bit |
| mod_clk | output | 1 | Modulator clock, `clk`/4 |
| sample_o | output | OUT_W | Merged signed sample |
| sample_vld | output | 1 | One-cycle strobe for a new sample |
| settled | output | 1 | Enough fresh samples taken since restart |

## Verification
The hardest situation to reach is a restart strobe that lands on the very master edge where a capture would happen. Only a narrow phase window produces it. A close second is a restart that comes just before or after the sixteenth capture. The bench keeps its own phase count of the divider and uses it to place `sync_i` exactly on a capture edge. Random restarts are spaced widely enough that the settled boundary is crossed many times. Random and fixed bit patterns, such as all ones, all zeros and alternating bits, are checked against a reference sum that is computed in the bench.

// File: rtl/dsm_merge_pkg.sv
package dsm_merge_pkg;
  // Ternary contribution of one modulator bit: +1, -1 or 0 (history empty)
  typedef logic signed [1:0] tri_t;

  localparam int M0_TAPS = 4;
  localparam int M1_TAPS = 2;

  function automatic tri_t bit_to_tri(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction
endpackage

// File: rtl/dsm_tap_line.sv
module dsm_tap_line
  import dsm_merge_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift,
  input  tri_t                 din,
  output tri_t [DEPTH-1:0]     taps
);
  tri_t [DEPTH-1:0] tap_q, tap_d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    tri_t src;
    if (k == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = tap_q[k-1];
    end

    always_comb begin
      tap_d[k] = tap_q[k];
      if (clr)        tap_d[k] = '0;
      else if (shift) tap_d[k] = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[k] <= '0;
      else        tap_q[k] <= tap_d[k];
    end
  end

  assign taps = tap_q;
endmodule

// File: rtl/dsm_modclk_div.sv
module dsm_modclk_div (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic mod_clk,
  output logic take
);
  // Phases 0..3 form the running cycle (high in 1 and 2); 4..7 are a
  // one-shot hold-off entered on restart, giving five low cycles.
  localparam logic [2:0] PH_WRAP  = 3'd3;
  localparam logic [2:0] PH_START = 3'd4;
  localparam logic [2:0] PH_RISE  = 3'd0;
  localparam logic [2:0] PH_HI_A  = 3'd1;
  localparam logic [2:0] PH_HI_B  = 3'd2;

  logic [2:0] ph_q, ph_d;
  logic       mclk_q, mclk_d;

  always_comb begin
    take = (ph_q == PH_RISE) && !sync_i;
    if (sync_i)              ph_d = PH_START;
    else if (ph_q == PH_WRAP) ph_d = PH_RISE;
    else                      ph_d = ph_q + 3'd1;
    mclk_d = (ph_d == PH_HI_A) || (ph_d == PH_HI_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_START;
      mclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mclk_q <= mclk_d;
    end
  end

  assign mod_clk = mclk_q;

  assert_sync_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !mod_clk);
  assert_high_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mod_clk) && !sync_i) |=> mod_clk);
  assert_low_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_clk) && !sync_i) |=> !mod_clk);
endmodule

// File: rtl/dsm_merge_core.sv
module dsm_merge_core
  import dsm_merge_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  tri_t                   m1_new,
  input  tri_t [M0_TAPS-1:0]     m0_taps,
  input  tri_t [M1_TAPS-1:0]     m1_taps,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [OUT_W-1:0] K2 = OUT_W'(2);
  localparam logic signed [OUT_W-1:0] K3 = OUT_W'(3);
  localparam logic signed [OUT_W-1:0] K4 = OUT_W'(4);
  localparam logic signed [OUT_W-1:0] K6 = OUT_W'(6);
  localparam logic signed [OUT_W-1:0] K9 = OUT_W'(9);

  function automatic logic signed [OUT_W-1:0] ext(input tri_t v);
    return {{(OUT_W-2){v[1]}}, v};
  endfunction

  // m0_taps[k] holds M0[n-1-k]; m1_taps[k] holds M1[n-1-k]
  logic signed [OUT_W-1:0] m1_diff2, m0_sum;

  always_comb begin
    m1_diff2 = ext(m1_new) - K2 * ext(m1_taps[0]) + ext(m1_taps[1]);
    m0_sum   = K3 * ext(m0_taps[1]) - K6 * ext(m0_taps[2]) + K4 * ext(m0_taps[3]);
    y        = m0_sum + K9 * m1_diff2;
  end
endmodule

// File: rtl/dsm_stream_merge.sv
module dsm_stream_merge
  import dsm_merge_pkg::*;
#(
  parameter int OUT_W    = 8,
  parameter int SETTLE_N = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic                    m0_bit,
  input  logic                    m1_bit,
  output logic                    mod_clk,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sample_vld,
  output logic                    settled
);
  localparam int CW = $clog2(SETTLE_N + 1);
  localparam logic [CW-1:0] SETTLE_MAX = CW'(SETTLE_N);

  // Reset: asserted asynchronously, released after two clk edges
  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  logic take;
  dsm_modclk_div i_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sync_i  (sync_i),
    .mod_clk (mod_clk),
    .take    (take)
  );

  tri_t m0_new, m1_new;
  tri_t [M0_TAPS-1:0] m0_taps;
  tri_t [M1_TAPS-1:0] m1_taps;
  assign m0_new = bit_to_tri(m0_bit);
  assign m1_new = bit_to_tri(m1_bit);

  dsm_tap_line #(.DEPTH(M0_TAPS)) i_m0_line (
    .clk (clk), .rst_n (rst_core_n), .clr (sync_i), .shift (take),
    .din (m0_new), .taps (m0_taps)
  );
  dsm_tap_line #(.DEPTH(M1_TAPS)) i_m1_line (
    .clk (clk), .rst_n (rst_core_n), .clr (sync_i), .shift (take),
    .din (m1_new), .taps (m1_taps)
  );

  logic signed [OUT_W-1:0] y_c;
  dsm_merge_core #(.OUT_W(OUT_W)) i_core (
    .m1_new  (m1_new),
    .m0_taps (m0_taps),
    .m1_taps (m1_taps),
    .y       (y_c)
  );

  logic signed [OUT_W-1:0] smp_q, smp_d;
  logic                    vld_q, vld_d;
  logic [CW-1:0]           cnt_q, cnt_d;

  always_comb begin
    smp_d = take ? y_c : smp_q;
    vld_d = take;
    cnt_d = cnt_q;
    if (sync_i)                          cnt_d = '0;
    else if (take && cnt_q != SETTLE_MAX) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      smp_q <= '0;
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      smp_q <= smp_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  assign sample_o   = smp_q;
  assign sample_vld = vld_q;
  assign settled    = (cnt_q == SETTLE_MAX);

  assert_vld_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    sample_vld |-> $rose(mod_clk));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !sample_vld |-> $stable(sample_o));
  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    sample_vld |-> (sample_o <= 49 && sample_o >= -49));
  assert_settle_clear_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    sync_i |=> !settled);
  assert_settle_with_vld_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(settled) |-> sample_vld);
  assert_no_take_on_sync_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    sync_i |=> !sample_vld);
endmodule

// File: tb/test_dsm_stream_merge.sv
module test_dsm_stream_merge;
  localparam time CLK_PERIOD = 10ns;
  localparam int  OUT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic m0_bit = 1'b0;
  logic m1_bit = 1'b0;
  logic mod_clk, sample_vld, settled;
  logic signed [OUT_W-1:0] sample_o;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm_stream_merge #(.OUT_W(OUT_W), .SETTLE_N(16)) i_dsm_stream_merge (
    .clk (clk), .rst_n (rst_n), .sync_i (sync_i),
    .m0_bit (m0_bit), .m1_bit (m1_bit),
    .mod_clk (mod_clk), .sample_o (sample_o),
    .sample_vld (sample_vld), .settled (settled)
  );

  // ---------------- reference model ----------------
  int rel, p, y_e, sc, since;
  bit vld_e;
  int h0 [0:4];
  int h1 [0:2];

  function automatic int tv(input logic b);
    return b ? 1 : -1;
  endfunction

  function automatic bit mclk_exp(input int ph);
    return (ph >= 5) && (((ph - 5) % 4) < 2);
  endfunction

  function automatic int merge_ref(input int a0[0:4], input int a1[0:2]);
    return 3*a0[2] - 6*a0[3] + 4*a0[4] + 9*(a1[0] - 2*a1[1] + a1[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; p = 0; y_e = 0; sc = 0; since = 0; vld_e = 1'b0;
      for (int k = 0; k < 5; k++) h0[k] = 0;
      for (int k = 0; k < 3; k++) h1[k] = 0;
    end else if (rel < 2) begin
      rel++;
    end else if (sync_i) begin
      p = 0; sc = 0; since = 0; vld_e = 1'b0;
      for (int k = 0; k < 5; k++) h0[k] = 0;
      for (int k = 0; k < 3; k++) h1[k] = 0;
    end else begin
      p++;
      if (p >= 5 && ((p - 5) % 4) == 0) begin
        for (int k = 4; k > 0; k--) h0[k] = h0[k-1];
        for (int k = 2; k > 0; k--) h1[k] = h1[k-1];
        h0[0] = tv(m0_bit);
        h1[0] = tv(m1_bit);
        y_e = merge_ref(h0, h1);
        vld_e = 1'b1;
        if (sc < 16) sc++;
        since++;
      end else begin
        vld_e = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1/R2/R3 mod_clk", int'(mod_clk), int'(mclk_exp(p)));
      chk("R4/R9 sample_vld", int'(sample_vld), int'(vld_e));
      if (since <= 4) chk("R7 sample_o", int'(sample_o), y_e);
      else            chk("R5/R6 sample_o", int'(sample_o), y_e);
      chk("R8 settled", int'(settled), int'(sc >= 16));
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // pattern: 0 random, 1 all ones, 2 all zeros, 3 alternating
  task automatic run(input int cycles, input int pat, input int sync_odds);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      case (pat)
        1: begin m0_bit = 1'b1; m1_bit = 1'b1; end
        2: begin m0_bit = 1'b0; m1_bit = 1'b0; end
        3: begin m0_bit = i[0]; m1_bit = ~i[1]; end
        default: begin m0_bit = 1'($urandom); m1_bit = 1'($urandom); end
      endcase
      sync_i = (sync_odds > 0) && (($urandom % sync_odds) == 0);
    end
  endtask

  // R9: raise sync exactly at the edge where a capture is due
  task automatic sync_on_capture();
    do begin
      @(negedge clk);
      #1;
      sync_i = 1'b0;
      m0_bit = 1'($urandom); m1_bit = 1'($urandom);
    end while (!(p >= 4 && ((p - 4) % 4) == 0));
    sync_i = 1'b1;
    @(negedge clk);
    #1;
    sync_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #2;
    chk("R3 reset mod_clk", int'(mod_clk), 0);
    chk("R3 reset sample_vld", int'(sample_vld), 0);
    chk("R3 reset sample_o", int'(sample_o), 0);
    chk("R3 reset settled", int'(settled), 0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    chk("R3 reset mod_clk", int'(mod_clk), 0);
    chk("R3 reset sample_o", int'(sample_o), 0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    chk_on = 1'b1;
    run(200, 1, 0);
    run(200, 2, 0);
    run(200, 3, 0);
    run(300, 0, 0);
    repeat (6) begin
      sync_on_capture();
      run(90, 0, 0);
    end
    run(3000, 0, 150);
    run(300, 0, 12);
    chk_on = 1'b0;
    do_reset();
    chk_on = 1'b1;
    run(400, 0, 0);
    sync_on_capture();
    run(200, 1, 0);
    chk_on = 1'b0;
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule